// File: doc/BRIEF.md
# Triggered Single-Transfer Data Mover

This block moves data between memory locations on behalf of up to eight event sources without involving the processor. Each channel holds a source pointer, a destination pointer and a control word. The control word sets the transfer width (byte or word), the pointer to advance, and a transfer counter. A pulse on a channel's trigger input requests one service. The service copies a single byte or word from the source pointer to the destination pointer using one read and one write on a simple request/acknowledge memory port. After the write is acknowledged, the chosen pointer steps forward by the transfer size and the counter counts down.

When a triggered channel's counter is already zero, the engine makes no memory access. It pulses that channel's interrupt output instead, so the processor can run its normal handler for the event. A counter value of all ones marks a channel as continuous: it transfers on every trigger and its counter never changes. Triggers are held until served. When several are pending, the engine serves them one at a time, highest channel number first.

Software sets up channels through a write-only configuration port. The counter, the size flag and the increment selector share one control write.

Top module: `trig_xfer_engine`

## Requirements
- R1: A trigger pulse is held pending until that channel is granted. When several channels are pending, the highest-numbered one is served first, and one channel is served per service slot.
- R2: A service reads at the source pointer, then writes the value read to the destination pointer. Control bit 8 set selects a 16-bit word, and both the read and the write are marked wide. Control bit 8 clear moves the low byte, and the write data carries zeros above bit 7.
- R3: After a transfer, control bit 9 clear advances only the source pointer and bit 9 set advances only the destination pointer. The step is 1 for a byte and 2 for a word.
- R4: The 8-bit counter (control bits 7:0) decreases by one after each completed transfer. The value 0xFF marks continuous mode: that channel transfers on every trigger and never counts.
- R5: A channel serviced with a counter of zero makes no memory access and leaves its pointers unchanged. It raises its own interrupt output for exactly one cycle, and no memory request is active in that cycle.
- R6: Each transfer makes exactly one read followed by exactly one write. A request holds its address and direction until acknowledged, and channel state is updated only after the write acknowledge.
- R7: Configuration writes select the register with a 2-bit code: 0 sets the source pointer, 1 sets the destination pointer, 2 sets the control word. Each write affects only the addressed channel and register.
- R8: After reset no memory request or interrupt is active, no trigger is pending, and every pointer and counter is zero. A trigger on an unconfigured channel therefore raises its interrupt.
- R9: A trigger that arrives on a channel while that channel's own service is under way is kept, and it causes a second service afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_CH | Per-channel service trigger |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | log2(NUM_CH) | Channel addressed by the configuration write |
| cfg_sel_i | input | 2 | Register select: 0 source, 1 destination, 2 control |
| cfg_data_i | input | ADDR_W | Configuration write data |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_wide_o | output | 1 | 1 for a word access, 0 for a byte access |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with the acknowledge of a read |
| mem_ack_i | input | 1 | Memory acknowledge |
| irq_o | output | NUM_CH | Per-channel interrupt pulse when the counter is exhausted |

## Verification
The bench aims at the moment a counter reaches zero. A design that decremented once too often, or that still transferred at zero, would show an extra bus access or a missing interrupt pulse. Continuous channels get repeated triggers, which would expose a design that counted 0xFF down and later raised a stray interrupt. A same-cycle burst of three triggers checks the service order, and a retrigger during a channel's own service checks that the design does not swallow a request it clears at grant. Byte transfers read memory whose upper byte is non-zero, so leaked upper bits, a pointer stepping by the wrong size, or both pointers stepping all show up as wrong addresses or wrong memory contents.

// File: rtl/txe_pkg.sv
package txe_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_IRQ   = 2'd3
   } txe_state_e;

   localparam logic [1:0] CFG_SRC  = 2'd0;
   localparam logic [1:0] CFG_DST  = 2'd1;
   localparam logic [1:0] CFG_CTRL = 2'd2;

endpackage

// File: rtl/txe_chan_regs.sv
module txe_chan_regs
   import txe_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [$clog2(NUM_CH)-1:0] cfg_ch,
   input  logic [1:0]                cfg_sel,
   input  logic [ADDR_W-1:0]         cfg_data,
   input  logic                      upd_valid,
   input  logic [$clog2(NUM_CH)-1:0] upd_ch,
   input  logic [ADDR_W-1:0]         upd_src,
   input  logic [ADDR_W-1:0]         upd_dst,
   input  logic [CNT_W-1:0]          upd_cnt,
   output logic [ADDR_W-1:0]         src_o  [NUM_CH],
   output logic [ADDR_W-1:0]         dst_o  [NUM_CH],
   output logic [CNT_W-1:0]          cnt_o  [NUM_CH],
   output logic                      wide_o [NUM_CH],
   output logic                      incd_o [NUM_CH]
);
   localparam int CH_W     = $clog2(NUM_CH);
   localparam int WIDE_BIT = CNT_W;
   localparam int INCD_BIT = CNT_W + 1;
   localparam logic [CNT_W-1:0] CONT_CODE = {CNT_W{1'b1}};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit_cfg;
      logic hit_upd;

      assign hit_cfg = cfg_we && (cfg_ch == CH_W'(c));
      assign hit_upd = upd_valid && (upd_ch == CH_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            src_o[c]  <= '0;
            dst_o[c]  <= '0;
            cnt_o[c]  <= '0;
            wide_o[c] <= 1'b0;
            incd_o[c] <= 1'b0;
         end else if (hit_cfg) begin
            case (cfg_sel)
               CFG_SRC:  src_o[c] <= cfg_data;
               CFG_DST:  dst_o[c] <= cfg_data;
               CFG_CTRL: begin
                  cnt_o[c]  <= cfg_data[CNT_W-1:0];
                  wide_o[c] <= cfg_data[WIDE_BIT];
                  incd_o[c] <= cfg_data[INCD_BIT];
               end
               default: ;
            endcase
         end else if (hit_upd) begin
            src_o[c] <= upd_src;
            dst_o[c] <= upd_dst;
            cnt_o[c] <= upd_cnt;
         end
      end

      // R4: a continuous channel keeps its code unless software rewrites control
      a_r4_cont_hold : assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_o[c] == CONT_CODE && !(hit_cfg && cfg_sel == CFG_CTRL))
         |=> (cnt_o[c] == CONT_CODE));
   end

endmodule

// File: rtl/txe_prio_pick.sv
module txe_prio_pick #(
   parameter int NUM_CH = 8
) (
   input  logic [NUM_CH-1:0]         req,
   output logic                      any,
   output logic [$clog2(NUM_CH)-1:0] idx
);
   localparam int CH_W = $clog2(NUM_CH);

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (req[i]) begin
            any = 1'b1;
            idx = CH_W'(i);
         end
      end
   end

endmodule

// File: rtl/txe_mover.sv
module txe_mover
   import txe_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CH_W-1:0]   start_ch,
   input  logic [ADDR_W-1:0] start_src,
   input  logic [ADDR_W-1:0] start_dst,
   input  logic [CNT_W-1:0]  start_cnt,
   input  logic              start_wide,
   input  logic              start_incd,
   output logic              idle,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_wide,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              upd_valid,
   output logic [CH_W-1:0]   upd_ch,
   output logic [ADDR_W-1:0] upd_src,
   output logic [ADDR_W-1:0] upd_dst,
   output logic [CNT_W-1:0]  upd_cnt,
   output logic              irq_valid,
   output logic [CH_W-1:0]   irq_ch
);
   localparam logic [CNT_W-1:0]  CONT_CODE = {CNT_W{1'b1}};
   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 8);
   localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(1);

   txe_state_e        state_q;
   logic [CH_W-1:0]   ch_q;
   logic [ADDR_W-1:0] src_q;
   logic [ADDR_W-1:0] dst_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              wide_q;
   logic              incd_q;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ch_q    <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         wide_q  <= 1'b0;
         incd_q  <= 1'b0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  ch_q    <= start_ch;
                  src_q   <= start_src;
                  dst_q   <= start_dst;
                  cnt_q   <= start_cnt;
                  wide_q  <= start_wide;
                  incd_q  <= start_incd;
                  state_q <= (start_cnt == '0) ? ST_IRQ : ST_READ;
               end
            end
            ST_READ: begin
               if (mem_ack) begin
                  data_q  <= wide_q ? mem_rdata
                                    : {{(DATA_W-8){1'b0}}, mem_rdata[7:0]};
                  state_q <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (mem_ack) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      idle      = (state_q == ST_IDLE);
      mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
      mem_we    = (state_q == ST_WRITE);
      mem_wide  = wide_q;
      mem_addr  = (state_q == ST_WRITE) ? dst_q : src_q;
      mem_wdata = data_q;
      step      = wide_q ? WORD_STEP : BYTE_STEP;
      upd_valid = (state_q == ST_WRITE) && mem_ack;
      upd_ch    = ch_q;
      upd_src   = incd_q ? src_q : src_q + step;
      upd_dst   = incd_q ? dst_q + step : dst_q;
      upd_cnt   = (cnt_q == CONT_CODE) ? cnt_q : cnt_q - 1'b1;
      irq_valid = (state_q == ST_IRQ);
      irq_ch    = ch_q;
   end

   // R6: an unacknowledged request keeps its address and direction
   a_r6_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R6: an acknowledged read is followed directly by the write
   a_r6_read_then_write : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

   // R6: one write per service, the bus is released after it
   a_r6_single_write : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> !mem_req);

   // R2: the low byte written is the low byte that was read
   a_r2_data_carried : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (mem_wdata[7:0] == $past(mem_rdata[7:0])));

endmodule

// File: rtl/trig_xfer_engine.sv
module trig_xfer_engine
   import txe_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         trig_i,
   input  logic                      cfg_we_i,
   input  logic [$clog2(NUM_CH)-1:0] cfg_ch_i,
   input  logic [1:0]                cfg_sel_i,
   input  logic [ADDR_W-1:0]         cfg_data_i,
   output logic                      mem_req_o,
   output logic                      mem_we_o,
   output logic                      mem_wide_o,
   output logic [ADDR_W-1:0]         mem_addr_o,
   output logic [DATA_W-1:0]         mem_wdata_o,
   input  logic [DATA_W-1:0]         mem_rdata_i,
   input  logic                      mem_ack_i,
   output logic [NUM_CH-1:0]         irq_o
);
   localparam int CH_W = $clog2(NUM_CH);

   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a multiple of 8, at least 16");
   end
   if (CNT_W < 2 || ADDR_W < CNT_W + 2) begin : g_bad_cnt
      $error("ADDR_W must hold the control word of CNT_W+2 bits");
   end

   logic [ADDR_W-1:0] src_a  [NUM_CH];
   logic [ADDR_W-1:0] dst_a  [NUM_CH];
   logic [CNT_W-1:0]  cnt_a  [NUM_CH];
   logic              wide_a [NUM_CH];
   logic              incd_a [NUM_CH];

   logic [NUM_CH-1:0] pending_q;
   logic              pick_any;
   logic [CH_W-1:0]   pick_idx;
   logic              mv_idle;
   logic              grant;
   logic [NUM_CH-1:0] grant_mask;

   logic              upd_valid;
   logic [CH_W-1:0]   upd_ch;
   logic [ADDR_W-1:0] upd_src;
   logic [ADDR_W-1:0] upd_dst;
   logic [CNT_W-1:0]  upd_cnt;
   logic              irq_valid;
   logic [CH_W-1:0]   irq_ch;

   txe_chan_regs #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we_i),
      .cfg_ch    (cfg_ch_i),
      .cfg_sel   (cfg_sel_i),
      .cfg_data  (cfg_data_i),
      .upd_valid (upd_valid),
      .upd_ch    (upd_ch),
      .upd_src   (upd_src),
      .upd_dst   (upd_dst),
      .upd_cnt   (upd_cnt),
      .src_o     (src_a),
      .dst_o     (dst_a),
      .cnt_o     (cnt_a),
      .wide_o    (wide_a),
      .incd_o    (incd_a)
   );

   txe_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
      .req (pending_q),
      .any (pick_any),
      .idx (pick_idx)
   );

   assign grant      = mv_idle && pick_any;
   assign grant_mask = grant ? (NUM_CH'(1) << pick_idx) : '0;

   // pending is cleared at grant, so a retrigger during service is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending_q <= '0;
      else        pending_q <= (pending_q & ~grant_mask) | trig_i;
   end

   txe_mover #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .CH_W   (CH_W)
   ) u_mover (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (grant),
      .start_ch   (pick_idx),
      .start_src  (src_a[pick_idx]),
      .start_dst  (dst_a[pick_idx]),
      .start_cnt  (cnt_a[pick_idx]),
      .start_wide (wide_a[pick_idx]),
      .start_incd (incd_a[pick_idx]),
      .idle       (mv_idle),
      .mem_req    (mem_req_o),
      .mem_we     (mem_we_o),
      .mem_wide   (mem_wide_o),
      .mem_addr   (mem_addr_o),
      .mem_wdata  (mem_wdata_o),
      .mem_rdata  (mem_rdata_i),
      .mem_ack    (mem_ack_i),
      .upd_valid  (upd_valid),
      .upd_ch     (upd_ch),
      .upd_src    (upd_src),
      .upd_dst    (upd_dst),
      .upd_cnt    (upd_cnt),
      .irq_valid  (irq_valid),
      .irq_ch     (irq_ch)
   );

   assign irq_o = irq_valid ? (NUM_CH'(1) << irq_ch) : '0;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_pend_chk
      // R1: a pending trigger survives until its channel is granted
      a_r1_pending_hold : assert property (@(posedge clk) disable iff (!rst_n)
         (pending_q[c] && !grant_mask[c]) |=> pending_q[c]);
   end

   // R5: the interrupt pulse never overlaps a bus access
   a_r5_irq_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o != '0) |-> !mem_req_o);

   // R5: the interrupt lasts a single cycle
   a_r5_irq_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o != '0) |=> (irq_o == '0));

endmodule

// File: tb/tb_trig_xfer_engine.sv
`timescale 1ns/1ps
module tb_trig_xfer_engine;
   localparam int NCH = 8;
   localparam int AW  = 16;
   localparam int DW  = 16;
   localparam int CW  = 8;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [NCH-1:0] trig;
   logic           cfg_we;
   logic [2:0]     cfg_ch;
   logic [1:0]     cfg_sel;
   logic [AW-1:0]  cfg_data;
   logic           mem_req, mem_we, mem_wide;
   logic [AW-1:0]  mem_addr;
   logic [DW-1:0]  mem_wdata;
   logic [DW-1:0]  mem_rdata;
   logic           mem_ack;
   logic [NCH-1:0] irq;

   always #2 clk = ~clk;

   trig_xfer_engine #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig),
      .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .mem_ack_i(mem_ack), .irq_o(irq)
   );

   logic [7:0]  mem    [256];
   logic [7:0]  refmem [256];
   logic [AW-1:0] log_addr [512];
   logic          log_we   [512];
   logic          log_wide [512];
   logic [DW-1:0] log_data [512];
   int            log_n = 0;
   int            irq_cnt [NCH];

   logic [AW-1:0] m_src [NCH];
   logic [AW-1:0] m_dst [NCH];
   logic [7:0]    m_cnt [NCH];
   logic          m_word [NCH];
   logic          m_incd [NCH];

   int  nchk = 0;
   int  nerr = 0;
   bit  done = 0;

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // memory model: random acknowledge latency, logs every acknowledged access
   initial begin
      logic [7:0] a;
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (rst_n && mem_req && ($urandom % 3 != 0)) begin
            a = mem_addr[7:0];
            if (mem_we) begin
               mem[a] = mem_wdata[7:0];
               if (mem_wide) mem[a + 8'd1] = mem_wdata[15:8];
            end else begin
               mem_rdata = {mem[a + 8'd1], mem[a]};
            end
            if (log_n < 512) begin
               log_addr[log_n] = mem_addr;
               log_we[log_n]   = mem_we;
               log_wide[log_n] = mem_wide;
               log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
               log_n++;
            end
            mem_ack = 1'b1;
         end
      end
   end

   initial begin
      for (int c = 0; c < NCH; c++) irq_cnt[c] = 0;
      forever begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++) if (irq[c]) irq_cnt[c]++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   task automatic cfg_write(input int ch, input logic [1:0] sel, input logic [AW-1:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = sel; cfg_data = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // R7: code 0 source, 1 destination, 2 control {bit9 inc-dst, bit8 word, bits7:0 count}
   task automatic set_chan(input int ch, input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input logic [7:0] cnt, input bit word, input bit incd);
      cfg_write(ch, 2'd0, s);
      cfg_write(ch, 2'd1, d);
      cfg_write(ch, 2'd2, {6'd0, incd, word, cnt});
      m_src[ch] = s; m_dst[ch] = d; m_cnt[ch] = cnt; m_word[ch] = word; m_incd[ch] = incd;
   endtask

   task automatic pulse(input logic [NCH-1:0] m);
      @(negedge clk);
      trig = m;
      @(negedge clk);
      trig = '0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      int n = 0;
      while (quiet < 4 && n < 400) begin
         @(negedge clk);
         n++;
         if (mem_req || irq != '0) quiet = 0;
         else quiet++;
      end
   endtask

   function automatic logic [DW-1:0] ref_read(input logic [AW-1:0] ad, input bit word);
      logic [7:0] a = ad[7:0];
      return word ? {refmem[a + 8'd1], refmem[a]} : {8'h00, refmem[a]};
   endfunction

   // checks the read/write pair at log index i for channel ch and advances the model
   task automatic expect_xfer(input int ch, input int i);
      logic [DW-1:0] exp;
      logic [7:0]    a;
      logic [AW-1:0] step;
      exp = ref_read(m_src[ch], m_word[ch]);
      check(!log_we[i] && log_we[i+1], "R6", "read then write order",
            {log_we[i], log_we[i+1]}, 1);
      check(log_addr[i] == m_src[ch], "R3", "source address", log_addr[i], m_src[ch]);
      check(log_addr[i+1] == m_dst[ch], "R3", "destination address", log_addr[i+1], m_dst[ch]);
      check(log_wide[i] == m_word[ch] && log_wide[i+1] == m_word[ch], "R2", "access width",
            log_wide[i+1], m_word[ch]);
      check(log_data[i+1] == exp, "R2", "written data", log_data[i+1], exp);
      a = m_dst[ch][7:0];
      refmem[a] = exp[7:0];
      if (m_word[ch]) refmem[a + 8'd1] = exp[15:8];
      step = m_word[ch] ? 16'd2 : 16'd1;
      if (m_incd[ch]) m_dst[ch] = m_dst[ch] + step;
      else            m_src[ch] = m_src[ch] + step;
      if (m_cnt[ch] != 8'hFF) m_cnt[ch] = m_cnt[ch] - 8'd1;
   endtask

   task automatic check_mem(input string req);
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== refmem[i]) bad++;
      check(bad == 0, req, "memory image mismatching bytes", bad, 0);
   endtask

   task automatic serve_one(input int ch);
      int n0 = log_n;
      int i0 = irq_cnt[ch];
      pulse(NCH'(1) << ch);
      wait_idle();
      if (m_cnt[ch] == 8'd0) begin
         check(log_n == n0, "R5", "bus accesses at zero count", log_n - n0, 0);
         check(irq_cnt[ch] == i0 + 1, "R5", "interrupt pulses", irq_cnt[ch] - i0, 1);
      end else begin
         check(log_n == n0 + 2, "R6", "accesses per transfer", log_n - n0, 2);
         if (log_n == n0 + 2) expect_xfer(ch, n0);
         check(irq_cnt[ch] == i0, "R4", "no interrupt while counting", irq_cnt[ch] - i0, 0);
         check_mem("R2");
      end
   endtask

   initial begin
      int n0;
      int cnt_choice;
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'($urandom);
         refmem[i] = mem[i];
      end
      for (int c = 0; c < NCH; c++) begin
         m_src[c] = '0; m_dst[c] = '0; m_cnt[c] = '0; m_word[c] = 0; m_incd[c] = 0;
      end
      trig = '0; cfg_we = 0; cfg_ch = '0; cfg_sel = '0; cfg_data = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      trig = '1;
      @(negedge clk);
      check(mem_req == 1'b0 && irq == '0, "R8", "outputs in reset", {mem_req, irq}, 0);
      trig = '0;
      @(negedge clk);
      rst_n = 1'b1;
      begin
         int seen = 0;
         repeat (10) begin
            @(negedge clk);
            if (mem_req || irq != '0) seen++;
         end
         check(seen == 0, "R8", "activity after reset from triggers held in reset", seen, 0);
      end

      // R8: unconfigured channel has zero count, so it interrupts
      serve_one(5);

      // byte mode, source advances, count runs out (R2 R3 R4 R5)
      set_chan(3, 16'h0010, 16'h0080, 8'd3, 1'b0, 1'b0);
      repeat (3) serve_one(3);
      check(m_cnt[3] == 8'd0, "R4", "model count after three transfers", m_cnt[3], 0);
      serve_one(3);
      serve_one(3);

      // word mode, destination advances
      set_chan(1, 16'h0020, 16'h0040, 8'd2, 1'b1, 1'b1);
      repeat (3) serve_one(1);

      // continuous mode never counts, never interrupts (R4)
      set_chan(6, 16'h0030, 16'h0060, 8'hFF, 1'b0, 1'b1);
      repeat (5) serve_one(6);
      check(irq_cnt[6] == 0, "R4", "continuous channel interrupts", irq_cnt[6], 0);

      // R1: simultaneous triggers, highest channel first
      set_chan(0, 16'h00B0, 16'h00A0, 8'd1, 1'b0, 1'b0);
      set_chan(4, 16'h00B4, 16'h00A4, 8'd1, 1'b0, 1'b0);
      set_chan(7, 16'h00B7, 16'h00A7, 8'd1, 1'b0, 1'b0);
      n0 = log_n;
      pulse(8'b1001_0001);
      wait_idle();
      check(log_n == n0 + 6, "R1", "accesses for three channels", log_n - n0, 6);
      if (log_n == n0 + 6) begin
         check(log_addr[n0+1] == 16'h00A7, "R1", "first served", log_addr[n0+1], 16'h00A7);
         check(log_addr[n0+3] == 16'h00A4, "R1", "second served", log_addr[n0+3], 16'h00A4);
         check(log_addr[n0+5] == 16'h00A0, "R1", "third served", log_addr[n0+5], 16'h00A0);
         expect_xfer(7, n0);
         expect_xfer(4, n0 + 2);
         expect_xfer(0, n0 + 4);
      end
      check_mem("R1");

      // R9: retrigger during the channel's own service
      set_chan(2, 16'h0050, 16'h0070, 8'd4, 1'b1, 1'b0);
      n0 = log_n;
      pulse(8'b0000_0100);
      begin
         int n = 0;
         while (!mem_req && n < 50) begin @(negedge clk); n++; end
      end
      pulse(8'b0000_0100);
      wait_idle();
      check(log_n == n0 + 4, "R9", "accesses for retriggered channel", log_n - n0, 4);
      if (log_n == n0 + 4) begin
         expect_xfer(2, n0);
         expect_xfer(2, n0 + 2);
      end
      check_mem("R9");

      // R7: rewrite only the source of channel 2, destination must persist
      cfg_write(2, 2'd0, 16'h0090);
      m_src[2] = 16'h0090;
      serve_one(2);

      // random channel services against the bench model
      for (int it = 0; it < 60; it++) begin
         int ch = $urandom % NCH;
         if ($urandom % 3 == 0) begin
            cnt_choice = $urandom % 5;
            set_chan(ch, AW'($urandom % 16'h00E0), AW'($urandom % 16'h00E0),
                     (cnt_choice == 4) ? 8'hFF : 8'(cnt_choice),
                     1'($urandom), 1'($urandom));
         end
         serve_one(ch);
      end

      finish_run();
   end
endmodule